// File: doc/BRIEF.md
# Three-Pin MCU Port with Address-Decoded Chip Selects

This block runs a small I/O port of three pins that sits beside a microcontroller bus. Static configuration inputs set the role of each pin. A pin can be plain software I/O, driven from a data-out register and gated by a direction register. It can be an external select line that follows a single address-decode term with selectable active level. It can also be an input whose level goes straight into the neighbouring programmable logic. Two of the pins have a second, dedicated job. Pin 1 can become the clock source for the internal macrocell flip-flops. Pin 2 can become a chip-select input, and a high level on it puts the memory into standby.

The microcontroller reaches the port through three register offsets above a parameterised base address. Writes land on the bus write strobe. Reads are combinational and return either the synchronised pin levels or the stored register bits. Every decode term is defined by a care mask and a match value over the 16-bit address. Each pin also has a fast-slew bit, which is passed straight through to the pad.

Top module: `mcu_xport`

## Requirements
- R1: After reset the data-out and direction registers are zero, so a pin in GPIO mode (mode code 0) whose enable comes from the direction register does not drive.
- R2: A write with `bus_wr` high stores `bus_wdata` in the data-out register when `bus_addr` is BASE+1, and in the direction register when it is BASE+2. At those addresses the read data returns the stored value.
- R3: At BASE+0 the read data returns the pin levels through a two-flop synchroniser. A pin change made between edges appears after the second rising edge and not after the first.
- R4: In chip-select mode (mode code 1) the pin output is the decode result when the polarity bit is 1, and its inverse when the polarity bit is 0. The decode result is 1 exactly when `(bus_addr ^ cs_match) & cs_care` is zero for that pin's 16-bit slice.
- R5: In modes 0 and 1, a pin's output enable follows its own output-enable decode term (same care/match rule) when its `cfg_oe_pt` bit is 1, and its direction-register bit otherwise.
- R6: In GPIO mode the pin output equals its data-out register bit.
- R7: In logic-input mode (mode codes 2 and 3) the pin never drives, and `plc_in` carries the pin level with no register on the path. In the other modes `plc_in` for that pin is 0.
- R8: While `cfg_clk_pin` is 1, `mc_clk` follows pin 1 and pin 1 does not drive. Otherwise `mc_clk` is 0.
- R9: While `cfg_csi_pin` is 1, `mem_standby` equals the level on pin 2 and pin 2 does not drive. Otherwise `mem_standby` is 0.
- R10: `pin_fast` equals `cfg_slew` bit for bit.
- R11: Writes to addresses other than BASE+1 and BASE+2 change no register, and reads outside BASE+0 to BASE+2 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | MCU address bus |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 3 | Write data, one bit per pin |
| bus_rdata | output | 3 | Combinational read data |
| cfg_mode | input | 6 | Two-bit mode per pin; pin i at [2i+1:2i] |
| cfg_cs_pol | input | 3 | Chip-select active level per pin, 1 = high |
| cfg_oe_pt | input | 3 | Enable source per pin, 1 = decode term |
| cfg_slew | input | 3 | Fast-slew configuration per pin |
| cfg_clk_pin | input | 1 | Dedicate pin 1 as macrocell clock |
| cfg_csi_pin | input | 1 | Dedicate pin 2 as chip-select input |
| cs_care | input | 48 | Select-term care masks, pin i at [16i+15:16i] |
| cs_match | input | 48 | Select-term match values |
| oe_care | input | 48 | Enable-term care masks |
| oe_match | input | 48 | Enable-term match values |
| pin_in | input | 3 | Pad input levels |
| pin_out | output | 3 | Pad output levels |
| pin_oe | output | 3 | Pad driver enables |
| pin_fast | output | 3 | Pad fast-slew controls |
| plc_in | output | 3 | Unregistered pin levels into internal logic |
| mc_clk | output | 1 | Macrocell clock from pin 1 |
| mem_standby | output | 1 | Memory standby from pin 2 |

## Verification
The only stored state is the two port registers and the synchroniser. If one of them is wrong, a read at the matching offset shows it in the same cycle. A GPIO pin that takes its enable from the direction register shows it on `pin_out` or `pin_oe` at once. A synchroniser with the wrong depth shows up as a read at BASE+0 that changes one edge too early or too late. A fault in the decode or polarity path is not stored, so it appears on `pin_out` in the same cycle as the address that exposes it.

// File: rtl/xport_pkg.sv
package xport_pkg;
    typedef enum logic [1:0] {
        PM_GPIO     = 2'd0,
        PM_CHIPSEL  = 2'd1,
        PM_LOGIC_IN = 2'd2,
        PM_RSVD     = 2'd3
    } pin_mode_e;

    localparam int OFS_DIN  = 0;
    localparam int OFS_DOUT = 1;
    localparam int OFS_DIR  = 2;
    localparam int CLK_PIN  = 1;
    localparam int CSI_PIN  = 2;
endpackage

// File: rtl/xport_pterm.sv
module xport_pterm #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] care,
    input  logic [AW-1:0] match,
    output logic          hit
);
    // every cared bit must equal its match value
    assign hit = ~|((addr ^ match) & care);
endmodule

// File: rtl/xport_regs.sv
module xport_regs
    import xport_pkg::*;
#(
    parameter int          AW   = 16,
    parameter int          NPIN = 3,
    parameter logic [15:0] BASE = 16'h0200
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic [NPIN-1:0] bus_wdata,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] dout_q,
    output logic [NPIN-1:0] dir_q,
    output logic [NPIN-1:0] rdata
);
    localparam logic [AW-1:0] A_DIN  = AW'(BASE) + AW'(OFS_DIN);
    localparam logic [AW-1:0] A_DOUT = AW'(BASE) + AW'(OFS_DOUT);
    localparam logic [AW-1:0] A_DIR  = AW'(BASE) + AW'(OFS_DIR);

    logic [NPIN-1:0] sync_a, sync_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
            dir_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_DOUT) dout_q <= bus_wdata;
            if (bus_addr == A_DIR)  dir_q  <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a <= '0;
            sync_b <= '0;
        end else begin
            sync_a <= pin_in;
            sync_b <= sync_a;
        end
    end

    always_comb begin
        rdata = '0;
        if (bus_addr == A_DIN)       rdata = sync_b;
        else if (bus_addr == A_DOUT) rdata = dout_q;
        else if (bus_addr == A_DIR)  rdata = dir_q;
    end
endmodule

// File: rtl/xport_pin_slice.sv
module xport_pin_slice
    import xport_pkg::*;
(
    input  pin_mode_e mode,
    input  logic      cs_hit,
    input  logic      oe_hit,
    input  logic      cs_pol,
    input  logic      oe_pt,
    input  logic      dout,
    input  logic      dir,
    input  logic      force_in,
    input  logic      pad_in,
    output logic      pad_out,
    output logic      pad_oe,
    output logic      logic_in
);
    logic drive_en;

    always_comb begin
        drive_en = oe_pt ? oe_hit : dir;
        pad_out  = 1'b0;
        pad_oe   = 1'b0;
        logic_in = 1'b0;
        unique case (mode)
            PM_GPIO: begin
                pad_out = dout;
                pad_oe  = drive_en;
            end
            PM_CHIPSEL: begin
                pad_out = cs_pol ? cs_hit : ~cs_hit;
                pad_oe  = drive_en;
            end
            PM_LOGIC_IN, PM_RSVD: begin
                logic_in = pad_in;
            end
        endcase
        if (force_in) pad_oe = 1'b0;
    end
endmodule

// File: rtl/mcu_xport.sv
module mcu_xport
    import xport_pkg::*;
#(
    parameter int          AW   = 16,
    parameter int          NPIN = 3,
    parameter logic [15:0] BASE = 16'h0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    input  logic [2*NPIN-1:0] cfg_mode,
    input  logic [NPIN-1:0]   cfg_cs_pol,
    input  logic [NPIN-1:0]   cfg_oe_pt,
    input  logic [NPIN-1:0]   cfg_slew,
    input  logic              cfg_clk_pin,
    input  logic              cfg_csi_pin,
    input  logic [NPIN*AW-1:0] cs_care,
    input  logic [NPIN*AW-1:0] cs_match,
    input  logic [NPIN*AW-1:0] oe_care,
    input  logic [NPIN*AW-1:0] oe_match,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic [NPIN-1:0]   pin_fast,
    output logic [NPIN-1:0]   plc_in,
    output logic              mc_clk,
    output logic              mem_standby
);
    logic [NPIN-1:0] dout_q, dir_q, cs_hit, oe_hit;

    xport_regs #(.AW(AW), .NPIN(NPIN), .BASE(BASE)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .pin_in(pin_in), .dout_q(dout_q),
        .dir_q(dir_q), .rdata(bus_rdata)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        localparam bit IS_CLK = (i == CLK_PIN);
        localparam bit IS_CSI = (i == CSI_PIN);
        logic force_in;
        assign force_in = (IS_CLK && cfg_clk_pin) || (IS_CSI && cfg_csi_pin);

        xport_pterm #(.AW(AW)) cs_term_i (
            .addr(bus_addr), .care(cs_care[i*AW +: AW]),
            .match(cs_match[i*AW +: AW]), .hit(cs_hit[i])
        );
        xport_pterm #(.AW(AW)) oe_term_i (
            .addr(bus_addr), .care(oe_care[i*AW +: AW]),
            .match(oe_match[i*AW +: AW]), .hit(oe_hit[i])
        );
        xport_pin_slice slice_i (
            .mode(pin_mode_e'(cfg_mode[2*i +: 2])), .cs_hit(cs_hit[i]),
            .oe_hit(oe_hit[i]), .cs_pol(cfg_cs_pol[i]), .oe_pt(cfg_oe_pt[i]),
            .dout(dout_q[i]), .dir(dir_q[i]), .force_in(force_in),
            .pad_in(pin_in[i]), .pad_out(pin_out[i]), .pad_oe(pin_oe[i]),
            .logic_in(plc_in[i])
        );
    end

    assign pin_fast    = cfg_slew;
    assign mc_clk      = cfg_clk_pin & pin_in[CLK_PIN];
    assign mem_standby = cfg_csi_pin & pin_in[CSI_PIN];
endmodule

// File: rtl/mcu_xport_chk.sv
module mcu_xport_chk #(
    parameter int          AW   = 16,
    parameter int          NPIN = 3,
    parameter logic [15:0] BASE = 16'h0200
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     bus_addr,
    input logic [NPIN-1:0]   bus_rdata,
    input logic [2*NPIN-1:0] cfg_mode,
    input logic [NPIN-1:0]   cfg_slew,
    input logic              cfg_clk_pin,
    input logic              cfg_csi_pin,
    input logic [NPIN-1:0]   pin_in,
    input logic [NPIN-1:0]   pin_oe,
    input logic [NPIN-1:0]   pin_fast,
    input logic              mc_clk,
    input logic              mem_standby
);
    logic [1:0]      warm;
    logic [NPIN-1:0] listen_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm <= '0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    always_comb begin
        for (int i = 0; i < NPIN; i++) listen_mask[i] = cfg_mode[2*i+1];
    end

    // R7
    input_pins_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & listen_mask) == '0);

    // R8
    clk_pin_dedicated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clk_pin |-> (!pin_oe[1] && mc_clk == pin_in[1]));

    // R9
    csi_pin_dedicated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_csi_pin |-> (!pin_oe[2] && mem_standby == pin_in[2]));

    // R9
    standby_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_csi_pin |-> !mem_standby);

    // R3
    din_two_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && bus_addr == AW'(BASE)) |-> bus_rdata == $past(pin_in, 2));

    // R10
    slew_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_fast == cfg_slew);
endmodule

bind mcu_xport mcu_xport_chk #(.AW(AW), .NPIN(NPIN), .BASE(BASE)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .cfg_mode(cfg_mode), .cfg_slew(cfg_slew), .cfg_clk_pin(cfg_clk_pin),
    .cfg_csi_pin(cfg_csi_pin), .pin_in(pin_in), .pin_oe(pin_oe),
    .pin_fast(pin_fast), .mc_clk(mc_clk), .mem_standby(mem_standby)
);

// File: tb/mcu_xport_tb_top.sv
module mcu_xport_tb_top;
    localparam logic [15:0] BASE = 16'h0200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_wdata = '0;
    logic [2:0]  bus_rdata;
    logic [5:0]  cfg_mode = '0;
    logic [2:0]  cfg_cs_pol = '0, cfg_oe_pt = '0, cfg_slew = '0;
    logic        cfg_clk_pin = 1'b0, cfg_csi_pin = 1'b0;
    logic [47:0] cs_care = '0, cs_match = '0, oe_care = '0, oe_match = '0;
    logic [2:0]  pin_in = '0;
    logic [2:0]  pin_out, pin_oe, pin_fast, plc_in;
    logic        mc_clk, mem_standby;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    mcu_xport #(.BASE(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_mode(cfg_mode),
        .cfg_cs_pol(cfg_cs_pol), .cfg_oe_pt(cfg_oe_pt), .cfg_slew(cfg_slew),
        .cfg_clk_pin(cfg_clk_pin), .cfg_csi_pin(cfg_csi_pin),
        .cs_care(cs_care), .cs_match(cs_match), .oe_care(oe_care),
        .oe_match(oe_match), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_fast(pin_fast), .plc_in(plc_in),
        .mc_clk(mc_clk), .mem_standby(mem_standby)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [2:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_peek(input logic [15:0] a, output logic [2:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [2:0] d;
        bus_peek(BASE + 16'd1, d); check("R1 dout", 16'(d), 16'h0);
        bus_peek(BASE + 16'd2, d); check("R1 dir", 16'(d), 16'h0);
        check("R1 oe", 16'(pin_oe), 16'h0);
    endtask

    task automatic t_regs_gpio;
        logic [2:0] d;
        bus_write(BASE + 16'd1, 3'b101);
        bus_write(BASE + 16'd2, 3'b011);
        bus_peek(BASE + 16'd1, d); check("R2 dout", 16'(d), 16'h5);
        bus_peek(BASE + 16'd2, d); check("R2 dir", 16'(d), 16'h3);
        check("R6 out", 16'(pin_out), 16'h5);
        check("R5 dir oe", 16'(pin_oe), 16'h3);
        bus_write(BASE + 16'd5, 3'b111);
        bus_write(BASE + 16'd0, 3'b111);
        bus_peek(BASE + 16'd1, d); check("R11 dout kept", 16'(d), 16'h5);
        bus_peek(BASE + 16'd2, d); check("R11 dir kept", 16'(d), 16'h3);
        bus_peek(BASE + 16'd3, d); check("R11 unmapped read", 16'(d), 16'h0);
    endtask

    task automatic t_sync;
        logic [2:0] d;
        @(negedge clk); pin_in = 3'b110; bus_addr = BASE;
        @(negedge clk); bus_peek(BASE, d); check("R3 one edge", 16'(d), 16'h0);
        @(negedge clk); bus_peek(BASE, d); check("R3 two edges", 16'(d), 16'h6);
        pin_in = 3'b000;
    endtask

    task automatic t_chipsel;
        @(negedge clk);
        cfg_mode = 6'b00_00_01;
        cs_care[15:0] = 16'hF000; cs_match[15:0] = 16'h8000;
        cfg_cs_pol = 3'b001;
        bus_addr = 16'h8123; #1; check("R4 hit high", 16'(pin_out[0]), 16'h1);
        bus_addr = 16'h7123; #1; check("R4 miss high", 16'(pin_out[0]), 16'h0);
        cfg_cs_pol = 3'b000;
        bus_addr = 16'h8FFF; #1; check("R4 hit low", 16'(pin_out[0]), 16'h0);
        bus_addr = 16'h0000; #1; check("R4 miss low", 16'(pin_out[0]), 16'h1);
        check("R5 dir oe cs", 16'(pin_oe[0]), 16'h1);
        cfg_oe_pt = 3'b001; oe_care[15:0] = 16'h0001; oe_match[15:0] = 16'h0001;
        #1; check("R5 pt off", 16'(pin_oe[0]), 16'h0);
        bus_addr = 16'h0001; #1; check("R5 pt on", 16'(pin_oe[0]), 16'h1);
        cfg_oe_pt = 3'b000;
    endtask

    task automatic t_logic_in;
        @(negedge clk);
        cfg_mode = 6'b00_11_10;
        pin_in = 3'b011; #1;
        check("R7 plc", 16'(plc_in), 16'h3);
        check("R7 oe", 16'(pin_oe), 16'h0);
        pin_in = 3'b010; #1;
        check("R7 comb", 16'(plc_in), 16'h2);
        cfg_mode = 6'b0; #1;
        check("R7 gpio zero", 16'(plc_in), 16'h0);
    endtask

    task automatic t_dedicated;
        @(negedge clk);
        bus_write(BASE + 16'd2, 3'b111);
        cfg_clk_pin = 1'b1; pin_in = 3'b010; #1;
        check("R8 clk", 16'(mc_clk), 16'h1);
        check("R8 oe", 16'(pin_oe), 16'h5);
        cfg_clk_pin = 1'b0; #1;
        check("R8 off", 16'(mc_clk), 16'h0);
        cfg_csi_pin = 1'b1; pin_in = 3'b100; #1;
        check("R9 standby", 16'(mem_standby), 16'h1);
        check("R9 oe", 16'(pin_oe), 16'h3);
        pin_in = 3'b000; #1;
        check("R9 low", 16'(mem_standby), 16'h0);
        cfg_csi_pin = 1'b0; pin_in = 3'b100; #1;
        check("R9 off", 16'(mem_standby), 16'h0);
        cfg_slew = 3'b110; #1;
        check("R10 slew", 16'(pin_fast), 16'h6);
    endtask

    initial begin
        #100000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs_gpio();
        t_sync();
        t_chipsel();
        t_logic_in();
        t_dedicated();
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule